// File: doc/BRIEF.md
# Tick-Driven Calendar Counter with Deferred Register Commit

This block keeps wall-clock time (second, minute, hour) and a calendar date (day of month, month, year offset and a leap flag) in running counters that move forward only on a single-cycle one-second enable, `tick_1hz`. Software reaches the counters through three 32-bit registers on a plain memory-mapped bus: a control word, a date word and a time word. Reads are combinational and always return the running counters.

A write to the time or date word does not reach the counters at once. The written value is held, the matching busy flag in the control word is raised, and the value is loaded on the `COMMIT_TICKS`-th tick after the write. Software sets the time, polls until the time busy flag clears, and only then writes the date. The leap flag is a plain bit that software writes inside the date word. The February length follows this bit and is not worked out from the year.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year 0, leap 0) and the control word reads 0.
- R2: Register map on `reg_addr`: 0x0 control, 0x4 date, 0x8 time. Any other address reads 0. Read data is combinational in the cycle the address is presented.
- R3: Time word fields: second in bits 5:0, minute in bits 13:8, hour in bits 20:16. Date word fields: day in bits 4:0, month in bits 11:8, year offset in bits 23:16, leap flag in bit 24. All other bits read 0. Control word: time busy in bit 8, date busy in bit 7.
- R4: A write to the time (date) word sets the time (date) busy bit in the next cycle. Until the commit, the register still reads the previous running value.
- R5: With `COMMIT_TICKS`=1, the first tick after a write loads the held value, and the busy bit is clear from that same clock edge onward. A field group loaded on a tick is not also incremented on that tick.
- R6: A second write while busy replaces the held value and restarts the wait. A write in the same cycle as a tick defers the commit to a later tick, and busy stays set.
- R7: The counters change only on cycles with `tick_1hz` high. Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour.
- R8: A tick at 23:59:59 gives 00:00:00 and advances the date by one day.
- R9: Month length is 30 days for months 4, 6, 9 and 11, and 31 days for the other months except February. February has 29 days when the leap bit is 1 and 28 days when it is 0.
- R10: Day 31 of month 12 rolls to day 1 of month 1 and increments the year offset. Year offset 255 wraps to 0.
- R11: When a date commit lands on the tick where the time wraps past midnight, the committed date wins and the carry is dropped. When a time commit lands on a tick, the date does not advance.
- R12: Writes to the control word, or to an unmapped address, change no state. The busy bits are cleared only by the commit logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable for a one-second step |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |

## Verification
The interesting collisions are the tick that commits a held value and the tick that carries time past midnight into the date. The bench sets the time to 23:59:59, then writes a new date just before the wrapping tick, and expects the written date and not the advanced one. In the reverse case it commits a new time at 23:59:59 on a tick and expects the date to stay put. A second collision, between a bus write and a commit tick in the same cycle, is provoked by raising `reg_wen` and `tick_1hz` together. It is judged by busy still reading 1 and the counters showing a plain increment.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 8;

  // bit positions software decodes
  localparam int SEC_LSB   = 0;
  localparam int MIN_LSB   = 8;
  localparam int HR_LSB    = 16;
  localparam int DAY_LSB   = 0;
  localparam int MON_LSB   = 8;
  localparam int YEAR_LSB  = 16;
  localparam int LEAP_BIT  = 24;
  localparam int TBUSY_BIT = 8;
  localparam int DBUSY_BIT = 7;

  localparam int OFF_CTRL = 0;
  localparam int OFF_DATE = 4;
  localparam int OFF_TIME = 8;

  localparam int LAST_SEC  = 59;
  localparam int LAST_MIN  = 59;
  localparam int LAST_HR   = 23;
  localparam int LAST_MON  = 12;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } clk_time_t;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] yr;
    logic [MON_W-1:0]  mo;
    logic [DAY_W-1:0]  dy;
  } clk_date_t;

  function automatic logic [DAY_W-1:0] days_in(input logic [MON_W-1:0] mo,
                                                input logic leap);
    logic [DAY_W-1:0] n;
    case (mo)
      4'd2:                   n = leap ? DAY_W'(29) : DAY_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11: n = DAY_W'(30);
      default:                n = DAY_W'(31);
    endcase
    return n;
  endfunction

  function automatic logic [31:0] time_to_word(input clk_time_t t);
    logic [31:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = t.sc;
    w[MIN_LSB +: MIN_W] = t.mn;
    w[HR_LSB  +: HR_W]  = t.hr;
    return w;
  endfunction

  function automatic clk_time_t word_to_time(input logic [31:0] w);
    clk_time_t t;
    t.sc = w[SEC_LSB +: SEC_W];
    t.mn = w[MIN_LSB +: MIN_W];
    t.hr = w[HR_LSB  +: HR_W];
    return t;
  endfunction

  function automatic logic [31:0] date_to_word(input clk_date_t d);
    logic [31:0] w;
    w = '0;
    w[DAY_LSB  +: DAY_W]  = d.dy;
    w[MON_LSB  +: MON_W]  = d.mo;
    w[YEAR_LSB +: YEAR_W] = d.yr;
    w[LEAP_BIT]           = d.leap;
    return w;
  endfunction

  function automatic clk_date_t word_to_date(input logic [31:0] w);
    clk_date_t d;
    d.dy   = w[DAY_LSB  +: DAY_W];
    d.mo   = w[MON_LSB  +: MON_W];
    d.yr   = w[YEAR_LSB +: YEAR_W];
    d.leap = w[LEAP_BIT];
    return d;
  endfunction

endpackage

// File: rtl/rtc_commit.sv
module rtc_commit #(
  parameter int W     = 32,
  parameter int TICKS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] hold
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

  logic [CW-1:0] left_q;
  logic          last_tick;

  assign last_tick = (left_q == CW'(1));
  assign commit    = busy && tick && !wr_en && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      hold   <= '0;
    end else if (wr_en) begin
      busy   <= 1'b1;
      left_q <= CW'(TICKS);
      hold   <= wr_data;
    end else if (busy && tick) begin
      if (last_tick) begin
        busy   <= 1'b0;
        left_q <= '0;
      end else begin
        left_q <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  clk_time_t load_val,
  output clk_time_t cur,
  output logic      day_carry
);
  logic sec_end, min_end, hr_end;

  assign sec_end   = cur.sc >= SEC_W'(LAST_SEC);
  assign min_end   = cur.mn >= MIN_W'(LAST_MIN);
  assign hr_end    = cur.hr >= HR_W'(LAST_HR);
  assign day_carry = tick && !load && sec_end && min_end && hr_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (tick) begin
      if (load) begin
        cur <= load_val;
      end else if (!sec_end) begin
        cur.sc <= cur.sc + SEC_W'(1);
      end else begin
        cur.sc <= '0;
        if (!min_end) begin
          cur.mn <= cur.mn + MIN_W'(1);
        end else begin
          cur.mn <= '0;
          cur.hr <= hr_end ? '0 : cur.hr + HR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  clk_date_t load_val,
  input  logic      adv,
  output clk_date_t cur
);
  logic [DAY_W-1:0] month_len;
  logic             day_end, mon_end;

  assign month_len = days_in(cur.mo, cur.leap);
  assign day_end   = cur.dy >= month_len;
  assign mon_end   = cur.mo >= MON_W'(LAST_MON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur.leap <= 1'b0;
      cur.yr   <= '0;
      cur.mo   <= MON_W'(1);
      cur.dy   <= DAY_W'(1);
    end else if (load) begin
      cur <= load_val;
    end else if (adv) begin
      if (!day_end) begin
        cur.dy <= cur.dy + DAY_W'(1);
      end else begin
        cur.dy <= DAY_W'(1);
        if (!mon_end) begin
          cur.mo <= cur.mo + MON_W'(1);
        end else begin
          cur.mo <= MON_W'(1);
          cur.yr <= cur.yr + YEAR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int COMMIT_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFF_TIME);
  localparam int NCH = 2; // channel 0 = time, 1 = date

  logic [NCH-1:0]       ch_wr, ch_busy, ch_commit;
  logic [NCH-1:0][31:0] ch_hold;

  assign ch_wr[0] = reg_wen && (reg_addr == A_TIME);
  assign ch_wr[1] = reg_wen && (reg_addr == A_DATE);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rtc_commit #(.W(32), .TICKS(COMMIT_TICKS)) u_commit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wr[g]),
      .wr_data (reg_wdata),
      .tick    (tick_1hz),
      .busy    (ch_busy[g]),
      .commit  (ch_commit[g]),
      .hold    (ch_hold[g])
    );
  end

  // named events for the checker
  logic        time_busy, date_busy, time_commit, date_commit, day_carry;
  logic [31:0] time_now_w, date_now_w, time_hold_w, date_hold_w;
  clk_time_t   time_now;
  clk_date_t   date_now;

  assign time_busy   = ch_busy[0];
  assign date_busy   = ch_busy[1];
  assign time_commit = ch_commit[0];
  assign date_commit = ch_commit[1];

  rtc_time_cnt u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .load      (time_commit),
    .load_val  (word_to_time(ch_hold[0])),
    .cur       (time_now),
    .day_carry (day_carry)
  );

  rtc_date_cnt u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (date_commit),
    .load_val (word_to_date(ch_hold[1])),
    .adv      (day_carry),
    .cur      (date_now)
  );

  assign time_now_w  = time_to_word(time_now);
  assign date_now_w  = date_to_word(date_now);
  assign time_hold_w = time_to_word(word_to_time(ch_hold[0]));
  assign date_hold_w = date_to_word(word_to_date(ch_hold[1]));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[TBUSY_BIT] = time_busy;
        reg_rdata[DBUSY_BIT] = date_busy;
      end
      A_DATE:  reg_rdata = date_now_w;
      A_TIME:  reg_rdata = time_now_w;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              time_busy,
  input logic              date_busy,
  input logic              time_commit,
  input logic              date_commit,
  input logic [31:0]       time_now_w,
  input logic [31:0]       date_now_w,
  input logic [31:0]       time_hold_w,
  input logic [31:0]       date_hold_w
);
  AST_TIME_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(8)) |=> time_busy); // R4
  AST_DATE_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(4)) |=> date_busy); // R4
  AST_TIME_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    time_commit |=> !time_busy); // R5
  AST_TIME_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    time_commit |=> time_now_w == $past(time_hold_w)); // R5
  AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1hz |=> ($stable(time_now_w) && $stable(date_now_w))); // R7
  AST_DATE_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    date_commit |=> date_now_w == $past(date_hold_w)); // R11
  AST_BUSY_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (time_busy && !time_commit) |=> time_busy); // R12
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_1hz    (tick_1hz),
  .reg_wen     (reg_wen),
  .reg_addr    (reg_addr),
  .time_busy   (time_busy),
  .date_busy   (date_busy),
  .time_commit (time_commit),
  .date_commit (date_commit),
  .time_now_w  (time_now_w),
  .date_now_w  (date_now_w),
  .time_hold_w (time_hold_w),
  .date_hold_w (date_hold_w)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction
  function automatic logic [31:0] dw(int lp, int y, int mo, int d);
    return (32'(lp) << 24) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask
  task automatic wr(logic [3:0] a, logic [31:0] d, bit with_tick = 0);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d; tick_1hz = with_tick;
    @(negedge clk);
    reg_wen = 1'b0; tick_1hz = 1'b0;
  endtask
  task automatic step();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask
  task automatic expect_word(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask
  // load both words with one commit tick
  task automatic load_all(logic [31:0] t, logic [31:0] d);
    wr(4'h8, t);
    wr(4'h4, d);
    step();
  endtask

  task automatic t_reset();
    expect_word("R1 ctrl", 4'h0, 32'h0);
    expect_word("R1 time", 4'h8, 32'h0);
    expect_word("R1 date", 4'h4, 32'h0000_0101);
  endtask

  task automatic t_map();
    expect_word("R2 unmapped", 4'hC, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    expect_word("R12 ctrl write", 4'h0, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);
    expect_word("R12 unmapped write time", 4'h8, 32'h0);
    expect_word("R12 unmapped write date", 4'h4, 32'h0000_0101);
  endtask

  task automatic t_commit();
    wr(4'h8, tw(10, 20, 30) | 32'hFF00_C0C0);
    expect_word("R4 time busy", 4'h0, 32'h100);
    expect_word("R4 old time", 4'h8, 32'h0);
    repeat (5) @(negedge clk);
    expect_word("R12 busy held", 4'h0, 32'h100);
    step();
    expect_word("R5 busy clear", 4'h0, 32'h0);
    expect_word("R3 R5 time loaded", 4'h8, tw(10, 20, 30));
    step();
    expect_word("R7 second step", 4'h8, tw(10, 20, 31));
    repeat (4) @(negedge clk);
    expect_word("R7 no tick", 4'h8, tw(10, 20, 31));
    wr(4'h4, dw(1, 9, 7, 4));
    expect_word("R4 date busy", 4'h0, 32'h080);
    step();
    expect_word("R3 date loaded", 4'h4, dw(1, 9, 7, 4));
    expect_word("R5 time kept on date commit", 4'h8, tw(10, 20, 32));
  endtask

  task automatic t_rewrite();
    load_all(tw(1, 2, 3), dw(0, 1, 1, 1));
    wr(4'h8, tw(5, 5, 5));
    wr(4'h8, tw(6, 6, 6));
    step();
    expect_word("R6 last write wins", 4'h8, tw(6, 6, 6));
    wr(4'h8, tw(7, 7, 7));
    wr(4'h8, tw(8, 8, 8), 1'b1);
    expect_word("R6 busy after write+tick", 4'h0, 32'h100);
    expect_word("R6 plain increment", 4'h8, tw(6, 6, 7));
    step();
    expect_word("R6 deferred commit", 4'h8, tw(8, 8, 8));
  endtask

  task automatic t_roll_time();
    load_all(tw(0, 0, 59), dw(0, 1, 1, 1));
    step();
    expect_word("R7 sec->min", 4'h8, tw(0, 1, 0));
    load_all(tw(4, 59, 59), dw(0, 1, 1, 1));
    step();
    expect_word("R7 min->hour", 4'h8, tw(5, 0, 0));
    load_all(tw(23, 59, 59), dw(0, 2, 3, 14));
    step();
    expect_word("R8 midnight time", 4'h8, tw(0, 0, 0));
    expect_word("R8 midnight date", 4'h4, dw(0, 2, 3, 15));
  endtask

  task automatic month_case(string req, int lp, int mo, int d, logic [31:0] exp);
    load_all(tw(23, 59, 59), dw(lp, 20, mo, d));
    step();
    expect_word(req, 4'h4, exp);
  endtask

  task automatic t_months();
    month_case("R9 feb no leap", 0, 2, 28, dw(0, 20, 3, 1));
    month_case("R9 feb leap 28", 1, 2, 28, dw(1, 20, 2, 29));
    month_case("R9 feb leap 29", 1, 2, 29, dw(1, 20, 3, 1));
    month_case("R9 apr 30", 0, 4, 30, dw(0, 20, 5, 1));
    month_case("R9 nov 30", 0, 11, 30, dw(0, 20, 12, 1));
    month_case("R9 jan 30", 0, 1, 30, dw(0, 20, 1, 31));
    month_case("R9 aug 31", 0, 8, 31, dw(0, 20, 9, 1));
    month_case("R10 dec 31", 0, 12, 31, dw(0, 21, 1, 1));
    load_all(tw(23, 59, 59), dw(0, 255, 12, 31));
    step();
    expect_word("R10 year wrap", 4'h4, dw(0, 0, 1, 1));
  endtask

  task automatic t_collide();
    load_all(tw(23, 59, 58), dw(0, 3, 5, 20));
    step();
    wr(4'h4, dw(0, 3, 6, 10));
    step();
    expect_word("R11 date commit wins", 4'h4, dw(0, 3, 6, 10));
    expect_word("R11 time wrapped", 4'h8, tw(0, 0, 0));
    load_all(tw(23, 59, 58), dw(0, 3, 5, 20));
    step();
    wr(4'h8, tw(12, 0, 0));
    step();
    expect_word("R11 time commit no carry", 4'h4, dw(0, 3, 5, 20));
    expect_word("R11 time loaded", 4'h8, tw(12, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_commit();
    t_rewrite();
    t_roll_time();
    t_months();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule